// File: doc/BRIEF.md
# Programmable System Event Combiner

This block merges many separate signs of system activity into two event strobes that a power-management timer unit watches. The activity sources are a non-maskable interrupt line, the bus hold-acknowledge line, a set of general-purpose external pins, pulses from interrupt-group detection and hit lines from I/O or memory address decoders. The decoders and the timers themselves sit outside the block.

Each external pin has its own two-bit mode that picks its polarity and chooses between level and edge detection. The non-maskable interrupt counts only on its rising transition. A hold-acknowledge counts as activity only while no refresh cycle is in progress. A wide enable mask picks the sources that make up EventA. A narrower mask builds EventB from the external pins, the non-maskable interrupt and, optionally, EventA itself. A one-clock restart strobe for Timer A marks each new assertion of EventA.

The pins and the non-maskable interrupt may change at any time, so each passes through a two-flop synchronizer. The other sources are assumed to be synchronous to the block clock.

Top module: `evt_combiner`

## Requirements
- R1: A low-to-high transition of `nmi_in`, with `sel_a[0]` set, raises `event_a` for exactly one clock. A high-to-low transition or a steady level raises nothing.
- R2: While `sel_a[1]` is set, `hold_ack` high drives `event_a` high, but only in cycles where `refresh_busy` is low.
- R3: Pin mode 2'b00 makes the pin an event for as long as the pin is high.
- R4: Pin mode 2'b01 makes a one-clock event on each high-to-low edge of the pin.
- R5: Pin mode 2'b10 makes the pin an event for as long as the pin is low.
- R6: Pin mode 2'b11 makes a one-clock event on each low-to-high edge of the pin. For pin k the mode sits in `pin_mode[2k+1:2k]`.
- R7: `event_a` is the OR of all sources whose `sel_a` bit is set. The bit layout is 0 = NMI, 1 = hold, 2..1+NUM_PINS = pins, then the `irq_hit` bits, then the `decode_hit` bits. A source whose bit is clear has no effect.
- R8: `event_b` is the OR of the sources enabled in `sel_b`. Bit 0 chains in EventA, bits 1..NUM_PINS are the pin events and bit NUM_PINS+1 is the NMI event. These sources work independently of `sel_a`.
- R9: `timer_a_restart` is high for one clock in the cycle where `event_a` goes from low to high, and stays low while `event_a` remains high.
- R10: While `rst_n` is low, and in the first cycle after it is released, `event_a`, `event_b` and `timer_a_restart` are low.
- R11: A change on a synchronous source (`hold_ack`, `refresh_busy`, `irq_hit`, `decode_hit`, masks) shows at the outputs after one clock edge. A change on `nmi_in` or `ext_pin` shows after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Non-maskable interrupt line, asynchronous |
| hold_ack | input | 1 | Bus hold-acknowledge, high while an alternate master owns the bus |
| refresh_busy | input | 1 | High during memory refresh cycles; masks the hold event |
| ext_pin | input | NUM_PINS | General-purpose external event pins, asynchronous |
| pin_mode | input | 2*NUM_PINS | Two mode bits per pin |
| irq_hit | input | NUM_IRQ | Interrupt-group activity pulses |
| decode_hit | input | NUM_DEC | I/O or memory decode hit lines |
| sel_a | input | 2+NUM_PINS+NUM_IRQ+NUM_DEC | EventA source enable mask |
| sel_b | input | NUM_PINS+2 | EventB source enable mask |
| event_a | output | 1 | Combined EventA |
| event_b | output | 1 | Combined EventB |
| timer_a_restart | output | 1 | One-clock Timer A restart strobe |

## Verification
The hardest case to reach from the ports is an edge-mode pin event that lasts a single cycle. It appears only three clocks after the pin moves, and before that the pin has to sit at its starting level long enough to flush the synchronizer. If that settling is skipped, the history flop produces a false edge. The directed tests first park each pin at its starting level with every mask cleared. They then move the pin, and sample both the one cycle in which the event must appear and the cycle after it, where the event must be gone. A walked vector table covers the masking, the refresh qualification and the chaining of EventA into EventB through the synchronous sources.

// File: rtl/evt_pkg.sv
// Package: shared mode encoding and fixed source positions for the event
// combiner. Assumes the EventA mask puts NMI and hold below the pins.
package evt_pkg;

    // Two-bit mode per external pin (polarity and detection style).
    typedef enum logic [1:0] {
        MODE_LVL_HIGH = 2'b00,
        MODE_EDGE_FALL = 2'b01,
        MODE_LVL_LOW  = 2'b10,
        MODE_EDGE_RISE = 2'b11
    } pin_mode_e;

    // Fixed positions in the EventA source vector.
    localparam int SRC_A_NMI  = 0;
    localparam int SRC_A_HOLD = 1;
    localparam int SRC_A_PIN0 = 2;

    // Fixed positions in the EventB source vector.
    localparam int SRC_B_CHAIN = 0;
    localparam int SRC_B_PIN0  = 1;

    // Synchronizer depth for asynchronous inputs.
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/evt_sync_edge.sv
// Module: evt_sync_edge
// Brings one asynchronous input into the clock domain through a flop chain
// and gives the synchronized level plus one-clock rise and fall strobes.
// Assumes: the input is a level signal; reset clears the chain to low.
module evt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               prev;

    // Shift the input through the synchronizer stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // Compare the synchronized level with the one a clock earlier.
    always_comb begin
        level = chain_q[STAGES-1];
        prev  = chain_q[STAGES];
        rise  = level & ~prev;
        fall  = ~level & prev;
    end

endmodule

// File: rtl/evt_pin_mode.sv
// Module: evt_pin_mode
// Turns one synchronized pin into an event according to its two-bit mode:
// active-high level, falling edge, active-low level or rising edge.
// Assumes: rise and fall are one-clock strobes from evt_sync_edge.
module evt_pin_mode
    import evt_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       level,
    input  logic       rise,
    input  logic       fall,
    output logic       pin_evt
);

    pin_mode_e mode_e;

    // Decode the mode and pick the matching detector output.
    always_comb begin
        mode_e = pin_mode_e'(mode);
        case (mode_e)
            MODE_LVL_HIGH:  pin_evt = level;
            MODE_EDGE_FALL: pin_evt = fall;
            MODE_LVL_LOW:   pin_evt = ~level;
            MODE_EDGE_RISE: pin_evt = rise;
            default:        pin_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/evt_merge.sv
// Module: evt_merge
// Masks and ORs the source vectors into EventA and EventB, chains EventA
// into the EventB vector, and registers both outputs and the restart strobe.
// Assumes: all source bits are synchronous to clk.
module evt_merge
    import evt_pkg::*;
#(
    parameter int A_W = 10,
    parameter int B_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] src_a,
    input  logic [A_W-1:0] sel_a,
    input  logic [B_W-2:0] src_b_own,
    input  logic [B_W-1:0] sel_b,
    output logic           event_a,
    output logic           event_b,
    output logic           restart
);

    logic           a_next;
    logic           b_next;
    logic [B_W-1:0] src_b;

    // Combine the enabled sources; EventA is folded into EventB's bit 0.
    always_comb begin
        a_next = |(src_a & sel_a);
        src_b  = {src_b_own, a_next};
        b_next = |(src_b & sel_b);
    end

    // Register the events and mark each new EventA assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_a <= 1'b0;
            event_b <= 1'b0;
            restart <= 1'b0;
        end else begin
            event_a <= a_next;
            event_b <= b_next;
            restart <= a_next & ~event_a;
        end
    end

endmodule

// File: rtl/evt_combiner.sv
// Module: evt_combiner (top)
// Collects NMI, hold, external-pin, interrupt-group and decode activity into
// EventA and EventB for a power-management timer, plus a Timer A restart.
// Assumes: hold_ack, refresh_busy, irq_hit, decode_hit and the masks are
// synchronous to clk; nmi_in and ext_pin may be asynchronous.
module evt_combiner
    import evt_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int NUM_IRQ  = 2,
    parameter int NUM_DEC  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  nmi_in,
    input  logic                                  hold_ack,
    input  logic                                  refresh_busy,
    input  logic [NUM_PINS-1:0]                   ext_pin,
    input  logic [2*NUM_PINS-1:0]                 pin_mode,
    input  logic [NUM_IRQ-1:0]                    irq_hit,
    input  logic [NUM_DEC-1:0]                    decode_hit,
    input  logic [2+NUM_PINS+NUM_IRQ+NUM_DEC-1:0] sel_a,
    input  logic [NUM_PINS+1:0]                   sel_b,
    output logic                                  event_a,
    output logic                                  event_b,
    output logic                                  timer_a_restart
);

    localparam int A_W = 2 + NUM_PINS + NUM_IRQ + NUM_DEC;
    localparam int B_W = NUM_PINS + 2;

    logic                nmi_level;
    logic                nmi_rise;
    logic                nmi_fall;
    logic                nmi_evt;
    logic                hold_evt;
    logic [NUM_PINS-1:0] pin_evt;
    logic [A_W-1:0]      src_a;
    logic [B_W-2:0]      src_b_own;

    // NMI: synchronize, then keep only the rising transition.
    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi_in),
        .level    (nmi_level),
        .rise     (nmi_rise),
        .fall     (nmi_fall)
    );

    // Per-pin synchronizer and mode decoder.
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic lvl;
            logic rs;
            logic fl;

            evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (ext_pin[p]),
                .level    (lvl),
                .rise     (rs),
                .fall     (fl)
            );

            evt_pin_mode u_mode (
                .mode    (pin_mode[2*p+1:2*p]),
                .level   (lvl),
                .rise    (rs),
                .fall    (fl),
                .pin_evt (pin_evt[p])
            );
        end
    endgenerate

    // Qualify the sources and assemble the two source vectors.
    always_comb begin
        nmi_evt   = nmi_rise & (nmi_level | ~nmi_fall);
        hold_evt  = hold_ack & ~refresh_busy;
        src_a     = {decode_hit, irq_hit, pin_evt, hold_evt, nmi_evt};
        src_b_own = {nmi_evt, pin_evt};
    end

    // Masking, combining and output registers.
    evt_merge #(.A_W(A_W), .B_W(B_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .sel_a     (sel_a),
        .src_b_own (src_b_own),
        .sel_b     (sel_b),
        .event_a   (event_a),
        .event_b   (event_b),
        .restart   (timer_a_restart)
    );

endmodule

// File: rtl/evt_combiner_chk.sv
// Module: evt_combiner_chk
// Property checker bound to evt_combiner; watches only its ports.
module evt_combiner_chk #(
    parameter int NUM_PINS = 2,
    parameter int NUM_IRQ  = 2,
    parameter int NUM_DEC  = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  hold_ack,
    input logic                                  refresh_busy,
    input logic [2+NUM_PINS+NUM_IRQ+NUM_DEC-1:0] sel_a,
    input logic [NUM_PINS+1:0]                   sel_b,
    input logic                                  event_a,
    input logic                                  event_b,
    input logic                                  timer_a_restart
);

    assert_hold_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hold_ack) && !$past(refresh_busy) && $past(sel_a[1]))
        |-> event_a);

    assert_quiet_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_a) == '0) |-> !event_a);

    assert_chain_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_b[0]) && event_a) |-> event_b);

    assert_b_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_b |-> ($past(sel_b) != '0));

    assert_restart_with_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timer_a_restart |-> event_a);

    assert_restart_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timer_a_restart |=> !timer_a_restart);

    assert_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (!event_a && !event_b && !timer_a_restart));

endmodule

bind evt_combiner evt_combiner_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .NUM_DEC  (NUM_DEC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hold_ack        (hold_ack),
    .refresh_busy    (refresh_busy),
    .sel_a           (sel_a),
    .sel_b           (sel_b),
    .event_a         (event_a),
    .event_b         (event_b),
    .timer_a_restart (timer_a_restart)
);

// File: tb/evt_combiner_test.sv
module evt_combiner_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_in = 1'b0;
    logic       hold_ack = 1'b0;
    logic       refresh_busy = 1'b0;
    logic [1:0] ext_pin = 2'b00;
    logic [3:0] pin_mode = 4'b0000;
    logic [1:0] irq_hit = 2'b00;
    logic [3:0] decode_hit = 4'b0000;
    logic [9:0] sel_a = '0;
    logic [3:0] sel_b = '0;
    logic       event_a;
    logic       event_b;
    logic       timer_a_restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evt_combiner uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .nmi_in          (nmi_in),
        .hold_ack        (hold_ack),
        .refresh_busy    (refresh_busy),
        .ext_pin         (ext_pin),
        .pin_mode        (pin_mode),
        .irq_hit         (irq_hit),
        .decode_hit      (decode_hit),
        .sel_a           (sel_a),
        .sel_b           (sel_b),
        .event_a         (event_a),
        .event_b         (event_b),
        .timer_a_restart (timer_a_restart)
    );

    typedef struct packed {
        logic       hold;
        logic       refr;
        logic [1:0] irq;
        logic [3:0] dec;
        logic [9:0] sa;
        logic [3:0] sb;
        logic       ea;
        logic       eb;
    } vec_t;

    // Synchronous-source vectors (R2, R7, R8, R11): one edge of latency.
    localparam vec_t TABLE [10] = '{
        '{1'b1, 1'b0, 2'b00, 4'b0000, 10'h002, 4'h0, 1'b1, 1'b0}, // R2 hold
        '{1'b1, 1'b1, 2'b00, 4'b0000, 10'h002, 4'h0, 1'b0, 1'b0}, // R2 refresh masks
        '{1'b1, 1'b0, 2'b00, 4'b0000, 10'h000, 4'h0, 1'b0, 1'b0}, // R7 disabled
        '{1'b0, 1'b0, 2'b01, 4'b0000, 10'h010, 4'h1, 1'b1, 1'b1}, // R7 irq0, R8 chain
        '{1'b0, 1'b0, 2'b10, 4'b0000, 10'h010, 4'h1, 1'b0, 1'b0}, // R7 irq1 masked
        '{1'b0, 1'b0, 2'b00, 4'b1000, 10'h200, 4'h1, 1'b1, 1'b1}, // R7 dec3
        '{1'b0, 1'b0, 2'b00, 4'b0100, 10'h200, 4'h1, 1'b0, 1'b0}, // R7 dec2 masked
        '{1'b0, 1'b0, 2'b10, 4'b0001, 10'h3FF, 4'h0, 1'b1, 1'b0}, // R7 all enabled
        '{1'b0, 1'b0, 2'b00, 4'b0000, 10'h3FF, 4'h1, 1'b0, 1'b0}, // R7 no activity
        '{1'b1, 1'b0, 2'b00, 4'b0000, 10'h002, 4'hE, 1'b1, 1'b0}  // R8 no chain
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_all();
        sel_a = '0; sel_b = '0; hold_ack = 1'b0; refresh_busy = 1'b0;
        irq_hit = '0; decode_hit = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: outputs low during reset even with an enabled active source.
        hold_ack = 1'b1; sel_a = 10'h002; sel_b = 4'h1;
        repeat (3) @(negedge clk);
        chk("R10 event_a in reset", event_a, 1'b0);
        chk("R10 event_b in reset", event_b, 1'b0);
        chk("R10 restart in reset", timer_a_restart, 1'b0);
        clear_all();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: drive at a negedge, sample after one edge (R11).
        for (int i = 0; i < 10; i++) begin
            hold_ack = TABLE[i].hold; refresh_busy = TABLE[i].refr;
            irq_hit = TABLE[i].irq; decode_hit = TABLE[i].dec;
            sel_a = TABLE[i].sa; sel_b = TABLE[i].sb;
            @(negedge clk);
            chk($sformatf("R7 table row %0d event_a", i), event_a, TABLE[i].ea);
            chk($sformatf("R8 table row %0d event_b", i), event_b, TABLE[i].eb);
        end
        clear_all();

        // R9: restart pulses once while the hold level keeps EventA high.
        sel_a = 10'h002; hold_ack = 1'b1;
        @(negedge clk);
        chk("R9 restart first cycle", timer_a_restart, 1'b1);
        @(negedge clk);
        chk("R9 restart second cycle", timer_a_restart, 1'b0);
        chk("R9 event_a still high", event_a, 1'b1);
        clear_all();

        // R3: pin0 active-high level.
        pin_mode = 4'b0000; sel_a = 10'h004;
        ext_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 pin level not before third edge", event_a, 1'b0);
        @(negedge clk);
        chk("R3 high level event", event_a, 1'b1);
        repeat (3) @(negedge clk);
        chk("R3 level held", event_a, 1'b1);
        ext_pin[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 low gives none", event_a, 1'b0);
        clear_all();

        // R4: pin0 falling edge.
        pin_mode = 4'b0001; ext_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        sel_a = 10'h004;
        repeat (2) @(negedge clk);
        chk("R4 rise gives none", event_a, 1'b0);
        ext_pin[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 falling edge event", event_a, 1'b1);
        chk("R9 restart on pin pulse", timer_a_restart, 1'b1);
        @(negedge clk);
        chk("R4 pulse one clock", event_a, 1'b0);
        clear_all();

        // R5: pin1 active-low level.
        pin_mode = 4'b1000; ext_pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        sel_a = 10'h008;
        @(negedge clk);
        chk("R5 high gives none", event_a, 1'b0);
        ext_pin[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 low level event", event_a, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5 level held", event_a, 1'b1);
        clear_all();

        // R6: pin1 rising edge; falling edge ignored.
        pin_mode = 4'b1100;
        sel_a = 10'h008;
        ext_pin[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 rising edge event", event_a, 1'b1);
        @(negedge clk);
        chk("R6 pulse one clock", event_a, 1'b0);
        ext_pin[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 fall gives none", event_a, 1'b0);
        @(negedge clk);
        chk("R6 fall gives none later", event_a, 1'b0);
        clear_all();

        // R1: NMI rising edge only.
        sel_a = 10'h001;
        nmi_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 nmi rise event", event_a, 1'b1);
        @(negedge clk);
        chk("R1 nmi held gives none", event_a, 1'b0);
        nmi_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 nmi fall gives none", event_a, 1'b0);
        clear_all();

        // R8: EventB own sources with EventA masked off.
        pin_mode = 4'b0000; ext_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        sel_b = 4'h2;
        @(negedge clk);
        chk("R8 pin0 in event_b", event_b, 1'b1);
        chk("R8 event_a stays low", event_a, 1'b0);
        sel_b = 4'h4;
        @(negedge clk);
        chk("R8 pin1 not active", event_b, 1'b0);
        ext_pin[0] = 1'b0;
        sel_b = 4'h8;
        repeat (4) @(negedge clk);
        nmi_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 nmi in event_b", event_b, 1'b1);
        chk("R8 nmi not in event_a", event_a, 1'b0);
        @(negedge clk);
        chk("R8 nmi pulse ends", event_b, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule